// File: doc/BRIEF.md
# Exception State Tracker and Prioritizer

This block holds the lifecycle state of every exception source of a small microcontroller core and names the source the core should take next. The sources are the non-maskable interrupt, the hard fault, three configurable faults (memory management, bus, usage), the supervisor call, the deferred service request, the system timer tick and a parameterized set of external interrupt lines. Each source is addressed by its exception number. External line n has exception number 16+n.

Hardware or software raises a source with a one-cycle pulse on its bit of `set_pend`. Each configurable source has an enable bit and an 8-bit priority field. The block compares the best enabled pending source against the current execution priority. The current execution priority is the most urgent priority among all active sources. A preemption request is raised when the pending source is strictly more urgent. The core acknowledges handler entry with `take_ack` and reports a handler's completion with `ret_valid`/`ret_num`. Reset clears every source to inactive.

Top module: `exc_tracker`

## Requirements
- R1: While `rst_n` is low and after it rises, every source is inactive (`pend_state` and `act_state` all zero), `win_valid` and `preempt` are 0, and `cur_prio` reads 256.
- R2: A `set_pend` pulse on an inactive source makes it pending (pend bit 1, act bit 0) one cycle later. On an active source it makes it active-and-pending (both bits 1).
- R3: When `take_ack` is high while `preempt` is high, the source named by `win_num` becomes active on the next edge: pending goes to active, and active-and-pending goes to active. When `preempt` is low, `take_ack` is ignored.
- R4: A `ret_valid` pulse with `ret_num` makes that source inactive if it was active, or pending if it was active-and-pending.
- R5: Handlers nest: a preempting source becomes active while the preempted source stays active.
- R6: Exception number 2 (NMI) has fixed priority -2 and number 3 (hard fault) has fixed priority -1. Both ignore `src_en` and their priority fields. While the NMI is active, `preempt` stays low.
- R7: Configurable sources use their 8-bit field at `prio_cfg[8*num +: 8]`, where a lower value is more urgent. `win_num` is the enabled pending source with the lowest priority value, and ties go to the lower exception number.
- R8: `preempt` is high only when a winner exists and its priority is strictly lower than `cur_prio`. Equal priority does not preempt.
- R9: A configurable source with `src_en` low can still become pending, but it is never reported as `win_num`.
- R10: Exception numbers 0, 1, 7 to 10, 12 and 13 never become pending, whatever `set_pend` carries.
- R11: `cur_prio` is the signed minimum priority over all active sources. It is 256 (thread level) when none is active.
- R12: External line n maps to exception number 16+n, up to the last line (number 97 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears every source |
| set_pend | input | NUM_EXC | One-cycle set-pending pulse per exception number |
| src_en | input | NUM_EXC | Per-source enable (ignored for numbers 2 and 3) |
| prio_cfg | input | NUM_EXC*PRIO_W | Configurable priority, field per exception number |
| take_ack | input | 1 | Handler entry for the current winner |
| ret_valid | input | 1 | Exception return strobe |
| ret_num | input | NUM_W | Exception number being returned from |
| win_valid | output | 1 | An enabled pending source exists |
| win_num | output | NUM_W | Exception number of the winner (0 when none) |
| preempt | output | 1 | Winner is more urgent than current execution priority |
| cur_prio | output | PRIO_W+2 | Signed current execution priority |
| pend_state | output | NUM_EXC | Pending bit per source |
| act_state | output | NUM_EXC | Active bit per source |

## Verification
The bench targets five cases that a plausible bug would get wrong:
- Equal-priority contention. Using less-or-equal instead of strictly-less would let the second of two equal sources preempt the first, or pick the higher number on a tie.
- A new request arriving while the same source is active, followed by a return. A design that drops the second request would leave the source inactive instead of pending.
- The fixed levels -2 and -1 with their enables cleared. A design that applies the enable to them would lose the NMI.
- A request on a disabled source or on a reserved number. A faulty design would either lose the pending bit or hand out a number that has no handler.
- The last external line. An off-by-one in the number mapping would lose it.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int EXC_NMI   = 2;
   localparam int EXC_HARD  = 3;
   localparam int IRQ_BASE  = 16;
   localparam int FIX_BIAS  = 3;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_PEND     = 2'd1,
      ST_ACT      = 2'd2,
      ST_ACT_PEND = 2'd3
   } exc_st_e;

   function automatic bit exc_exists(input int n);
      return (n >= EXC_NMI && n <= 6) || n == 11 || n == 14 || n == 15 || n >= IRQ_BASE;
   endfunction

   function automatic bit exc_fixed(input int n);
      return n == EXC_NMI || n == EXC_HARD;
   endfunction

endpackage

// File: rtl/exc_src_cell.sv
module exc_src_cell
   import exc_pkg::*;
#(
   parameter bit IMPL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic take_i,
   input  logic ret_i,
   output logic pend_o,
   output logic act_o
);

   exc_st_e st_q, st_d;
   logic    set_ok;

   assign set_ok = set_i & IMPL;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:     if (set_ok) st_d = ST_PEND;
         ST_PEND:     if (take_i) st_d = set_ok ? ST_ACT_PEND : ST_ACT;
         ST_ACT: begin
            if (ret_i)       st_d = set_ok ? ST_PEND : ST_IDLE;
            else if (set_ok) st_d = ST_ACT_PEND;
         end
         ST_ACT_PEND: begin
            if (take_i)     st_d = set_ok ? ST_ACT_PEND : ST_ACT;
            else if (ret_i) st_d = ST_PEND;
         end
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign pend_o = (st_q == ST_PEND) || (st_q == ST_ACT_PEND);
   assign act_o  = (st_q == ST_ACT)  || (st_q == ST_ACT_PEND);

endmodule

// File: rtl/exc_pick_min.sv
module exc_pick_min #(
   parameter int N     = 98,
   parameter int W     = 10,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]   cand,
   input  logic [N*W-1:0] prio,
   output logic           found,
   output logic [IDX_W-1:0] idx,
   output logic [W-1:0]   best
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '1;
      for (int k = 0; k < N; k++) begin
         if (cand[k] && (!found || prio[k*W +: W] < best)) begin
            found = 1'b1;
            idx   = IDX_W'(k);
            best  = prio[k*W +: W];
         end
      end
   end

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
   import exc_pkg::*;
#(
   parameter int NUM_IRQ = 82,
   parameter int PRIO_W  = 8,
   parameter int NUM_EXC = IRQ_BASE + NUM_IRQ,
   parameter int NUM_W   = $clog2(NUM_EXC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_EXC-1:0]        set_pend,
   input  logic [NUM_EXC-1:0]        src_en,
   input  logic [NUM_EXC*PRIO_W-1:0] prio_cfg,
   input  logic                      take_ack,
   input  logic                      ret_valid,
   input  logic [NUM_W-1:0]          ret_num,
   output logic                      win_valid,
   output logic [NUM_W-1:0]          win_num,
   output logic                      preempt,
   output logic signed [PRIO_W+1:0]  cur_prio,
   output logic [NUM_EXC-1:0]        pend_state,
   output logic [NUM_EXC-1:0]        act_state
);

   localparam int BP_W = PRIO_W + 2;
   localparam logic [BP_W-1:0] THREAD_B = BP_W'((1 << PRIO_W) + FIX_BIAS);

   if (NUM_IRQ < 1 || NUM_IRQ > 240) begin : g_bad_irq
      $error("exc_tracker: NUM_IRQ out of range 1..240");
   end
   if (PRIO_W < 3 || PRIO_W > 8) begin : g_bad_prio
      $error("exc_tracker: PRIO_W out of range 3..8");
   end
   if (NUM_EXC != IRQ_BASE + NUM_IRQ) begin : g_bad_num
      $error("exc_tracker: NUM_EXC must equal 16 + NUM_IRQ");
   end

   logic [NUM_EXC*BP_W-1:0] bprio;
   logic [NUM_EXC-1:0]      eff_en;
   logic [NUM_EXC-1:0]      take_v;
   logic [NUM_EXC-1:0]      ret_v;

   for (genvar i = 0; i < NUM_EXC; i++) begin : g_src
      if (i == EXC_NMI) begin : g_nmi
         assign bprio[i*BP_W +: BP_W] = BP_W'(FIX_BIAS - 2);
         assign eff_en[i] = 1'b1;
         logic unused_fixed;
         assign unused_fixed = ^{src_en[i], prio_cfg[i*PRIO_W +: PRIO_W]};
      end else if (i == EXC_HARD) begin : g_hard
         assign bprio[i*BP_W +: BP_W] = BP_W'(FIX_BIAS - 1);
         assign eff_en[i] = 1'b1;
         logic unused_fixed;
         assign unused_fixed = ^{src_en[i], prio_cfg[i*PRIO_W +: PRIO_W]};
      end else begin : g_cfg
         assign bprio[i*BP_W +: BP_W] = {2'b00, prio_cfg[i*PRIO_W +: PRIO_W]} + BP_W'(FIX_BIAS);
         assign eff_en[i] = src_en[i];
      end

      assign take_v[i] = take_ack & preempt & (win_num == NUM_W'(i));
      assign ret_v[i]  = ret_valid & (ret_num == NUM_W'(i));

      exc_src_cell #(
         .IMPL (exc_exists(i))
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_pend[i]),
         .take_i (take_v[i]),
         .ret_i  (ret_v[i]),
         .pend_o (pend_state[i]),
         .act_o  (act_state[i])
      );
   end

   logic [BP_W-1:0] win_b;
   logic            act_any;
   logic [NUM_W-1:0] act_idx;
   logic [BP_W-1:0] act_b;
   logic [BP_W-1:0] cur_b;

   exc_pick_min #(.N(NUM_EXC), .W(BP_W), .IDX_W(NUM_W)) u_pick_pend (
      .cand  (pend_state & eff_en),
      .prio  (bprio),
      .found (win_valid),
      .idx   (win_num),
      .best  (win_b)
   );

   exc_pick_min #(.N(NUM_EXC), .W(BP_W), .IDX_W(NUM_W)) u_pick_act (
      .cand  (act_state),
      .prio  (bprio),
      .found (act_any),
      .idx   (act_idx),
      .best  (act_b)
   );

   logic unused_act_idx;
   assign unused_act_idx = ^act_idx;

   assign cur_b    = act_any ? act_b : THREAD_B;
   assign cur_prio = $signed(cur_b - BP_W'(FIX_BIAS));
   assign preempt  = win_valid && (win_b < cur_b);

endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
   parameter int NUM_EXC = 98,
   parameter int NUM_W   = 7,
   parameter int PW      = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_EXC-1:0]   set_pend,
   input logic [NUM_EXC-1:0]   src_en,
   input logic                 take_ack,
   input logic                 ret_valid,
   input logic [NUM_W-1:0]     ret_num,
   input logic                 win_valid,
   input logic [NUM_W-1:0]     win_num,
   input logic                 preempt,
   input logic signed [PW+1:0] cur_prio,
   input logic [NUM_EXC-1:0]   pend_state,
   input logic [NUM_EXC-1:0]   act_state
);

   assert_nmi_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pend[2] && !(take_ack && preempt && win_num == NUM_W'(2))) |=> pend_state[2]);

   assert_take_activates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_ack && preempt) |=> act_state[$past(win_num)]);

   assert_return_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && act_state[ret_num] && !pend_state[ret_num] && !set_pend[ret_num])
      |=> (!act_state[$past(ret_num)] && !pend_state[$past(ret_num)]));

   assert_nmi_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_state[2] |-> (win_valid && win_num == NUM_W'(2)));

   assert_nmi_unpreempted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_state[2] |-> !preempt);

   assert_preempt_has_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      preempt |-> (win_valid && pend_state[win_num]));

   assert_disabled_skipped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (src_en[win_num] || win_num == NUM_W'(2) || win_num == NUM_W'(3)));

   assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pend_state[13:12], pend_state[10:7], pend_state[1:0]}) == 0);

   assert_thread_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (act_state == '0) |-> (cur_prio == 256));

   assert_nmi_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      act_state[2] |-> (cur_prio == -2));

endmodule

bind exc_tracker exc_tracker_chk #(
   .NUM_EXC (NUM_EXC),
   .NUM_W   (NUM_W),
   .PW      (PRIO_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .set_pend   (set_pend),
   .src_en     (src_en),
   .take_ack   (take_ack),
   .ret_valid  (ret_valid),
   .ret_num    (ret_num),
   .win_valid  (win_valid),
   .win_num    (win_num),
   .preempt    (preempt),
   .cur_prio   (cur_prio),
   .pend_state (pend_state),
   .act_state  (act_state)
);

// File: tb/sim_exc_tracker.sv
module sim_exc_tracker;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_IRQ = 82;
   localparam int NUM_EXC = 16 + NUM_IRQ;
   localparam int NUM_W   = $clog2(NUM_EXC);
   localparam int PW      = 8;

   localparam int OP_SET = 0;
   localparam int OP_ACK = 1;
   localparam int OP_RET = 2;

   typedef struct packed {
      logic [1:0]        op;
      logic [6:0]        num;
      logic              valid;
      logic [6:0]        win;
      logic              pre;
      logic signed [9:0] cur;
      logic              p;
      logic              a;
   } vec_t;

   localparam vec_t VECS [15] = '{
      '{2'd0, 7'd16, 1'b1, 7'd16, 1'b1, 10'sd256, 1'b1, 1'b0},
      '{2'd0, 7'd17, 1'b1, 7'd16, 1'b1, 10'sd256, 1'b1, 1'b0},
      '{2'd1, 7'd16, 1'b1, 7'd17, 1'b0, 10'sd64,  1'b0, 1'b1},
      '{2'd0, 7'd21, 1'b1, 7'd21, 1'b1, 10'sd64,  1'b1, 1'b0},
      '{2'd1, 7'd21, 1'b1, 7'd17, 1'b0, 10'sd32,  1'b0, 1'b1},
      '{2'd0, 7'd21, 1'b1, 7'd21, 1'b0, 10'sd32,  1'b1, 1'b1},
      '{2'd2, 7'd21, 1'b1, 7'd21, 1'b1, 10'sd64,  1'b1, 1'b0},
      '{2'd1, 7'd21, 1'b1, 7'd17, 1'b0, 10'sd32,  1'b0, 1'b1},
      '{2'd0, 7'd2,  1'b1, 7'd2,  1'b1, 10'sd32,  1'b1, 1'b0},
      '{2'd1, 7'd2,  1'b1, 7'd17, 1'b0, -10'sd2,  1'b0, 1'b1},
      '{2'd2, 7'd2,  1'b1, 7'd17, 1'b0, 10'sd32,  1'b0, 1'b0},
      '{2'd2, 7'd21, 1'b1, 7'd17, 1'b0, 10'sd64,  1'b0, 1'b0},
      '{2'd2, 7'd16, 1'b1, 7'd17, 1'b1, 10'sd256, 1'b0, 1'b0},
      '{2'd1, 7'd17, 1'b0, 7'd0,  1'b0, 10'sd64,  1'b0, 1'b1},
      '{2'd2, 7'd17, 1'b0, 7'd0,  1'b0, 10'sd256, 1'b0, 1'b0}
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [NUM_EXC-1:0]    set_pend = '0;
   logic [NUM_EXC-1:0]    src_en = '1;
   logic [NUM_EXC*PW-1:0] prio_cfg;
   logic                  take_ack = 1'b0;
   logic                  ret_valid = 1'b0;
   logic [NUM_W-1:0]      ret_num = '0;
   logic                  win_valid;
   logic [NUM_W-1:0]      win_num;
   logic                  preempt;
   logic signed [PW+1:0]  cur_prio;
   logic [NUM_EXC-1:0]    pend_state;
   logic [NUM_EXC-1:0]    act_state;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_tracker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .set_pend(set_pend), .src_en(src_en),
      .prio_cfg(prio_cfg), .take_ack(take_ack), .ret_valid(ret_valid),
      .ret_num(ret_num), .win_valid(win_valid), .win_num(win_num),
      .preempt(preempt), .cur_prio(cur_prio), .pend_state(pend_state),
      .act_state(act_state)
   );

   task automatic chk(input string req, input int actv, input int expv);
      total++;
      if (actv != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
      end
   endtask

   task automatic do_op(input int op, input int num);
      @(negedge clk);
      case (op)
         OP_SET:  set_pend[num] = 1'b1;
         OP_ACK:  take_ack = 1'b1;
         default: begin ret_valid = 1'b1; ret_num = NUM_W'(num); end
      endcase
      @(negedge clk);
      set_pend  = '0;
      take_ack  = 1'b0;
      ret_valid = 1'b0;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int n = 0; n < NUM_EXC; n++) prio_cfg[n*PW +: PW] = 8'h80;
      prio_cfg[16*PW +: PW] = 8'h40;
      prio_cfg[17*PW +: PW] = 8'h40;
      prio_cfg[21*PW +: PW] = 8'h20;
      prio_cfg[2*PW +: PW]  = 8'h00;
      prio_cfg[3*PW +: PW]  = 8'h00;

      repeat (3) @(negedge clk);
      #1;
      chk("R1 pend during reset", int'(|pend_state), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 act after reset", int'(|act_state), 0);
      chk("R1 win_valid after reset", int'(win_valid), 0);
      chk("R1 preempt after reset", int'(preempt), 0);
      chk("R11 cur_prio thread", int'(cur_prio), 256);

      // Vector walk: R2 R3 R4 R5 R7 R8 R11
      foreach (VECS[v]) begin
         do_op(int'(VECS[v].op), int'(VECS[v].num));
         chk($sformatf("R7 vec%0d win_valid", v), int'(win_valid), int'(VECS[v].valid));
         if (VECS[v].valid) chk($sformatf("R7 vec%0d win_num", v), int'(win_num), int'(VECS[v].win));
         chk($sformatf("R8 vec%0d preempt", v), int'(preempt), int'(VECS[v].pre));
         chk($sformatf("R11 vec%0d cur_prio", v), int'(cur_prio), int'(VECS[v].cur));
         chk($sformatf("R2 R3 R4 vec%0d pend", v), int'(pend_state[VECS[v].num]), int'(VECS[v].p));
         chk($sformatf("R5 vec%0d act", v), int'(act_state[VECS[v].num]), int'(VECS[v].a));
      end

      // R6: fixed levels ignore enable
      src_en[2] = 1'b0; src_en[3] = 1'b0;
      do_op(OP_SET, 3);
      chk("R6 hard fault wins", int'(win_num), 3);
      chk("R6 hard fault preempts", int'(preempt), 1);
      do_op(OP_ACK, 0);
      chk("R6 hard fault level", int'(cur_prio), -1);
      do_op(OP_SET, 16);
      chk("R6 irq under hard fault no preempt", int'(preempt), 0);
      do_op(OP_SET, 2);
      chk("R6 nmi wins", int'(win_num), 2);
      chk("R6 nmi preempts hard fault", int'(preempt), 1);
      do_op(OP_ACK, 0);
      chk("R6 nmi level", int'(cur_prio), -2);
      chk("R5 hard fault still active", int'(act_state[3]), 1);
      do_op(OP_RET, 2);
      do_op(OP_RET, 3);
      chk("R4 back to thread", int'(cur_prio), 256);
      chk("R8 irq now preempts", int'(preempt), 1);
      do_op(OP_ACK, 0);
      do_op(OP_RET, 16);
      src_en[2] = 1'b1; src_en[3] = 1'b1;

      // R9: disabled source pends but is not chosen
      src_en[19] = 1'b0;
      do_op(OP_SET, 19);
      chk("R9 disabled pend bit", int'(pend_state[19]), 1);
      chk("R9 disabled not chosen", int'(win_valid), 0);
      src_en[19] = 1'b1;
      #1;
      chk("R9 enabled now chosen", int'(win_num), 19);
      do_op(OP_ACK, 0);
      do_op(OP_RET, 19);
      chk("R4 irq19 cleared", int'(act_state[19]), 0);

      // R10: reserved numbers
      @(negedge clk);
      set_pend[0] = 1'b1; set_pend[1] = 1'b1;
      set_pend[10:7] = 4'hF; set_pend[13:12] = 2'h3;
      @(negedge clk);
      set_pend = '0;
      #1;
      chk("R10 reserved never pend", int'(|pend_state), 0);
      chk("R10 no winner", int'(win_valid), 0);

      // R12: last external line
      do_op(OP_SET, NUM_EXC - 1);
      chk("R12 last line pend", int'(pend_state[NUM_EXC-1]), 1);
      chk("R12 last line number", int'(win_num), NUM_EXC - 1);
      do_op(OP_ACK, 0);
      chk("R12 last line active", int'(act_state[NUM_EXC-1]), 1);
      chk("R11 default prio level", int'(cur_prio), 128);

      // R3: ack ignored without preempt
      do_op(OP_SET, 20);
      chk("R3 equal prio no preempt", int'(preempt), 0);
      do_op(OP_ACK, 0);
      chk("R3 ack ignored", int'(act_state[20]), 0);

      // R1: mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 reset clears pend", int'(|pend_state), 0);
      chk("R1 reset clears act", int'(|act_state), 0);
      chk("R1 reset cur_prio", int'(cur_prio), 256);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule